// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command-decoding front end of an asynchronous parallel NOR flash device. A host writes to it over a simple strobed bus. Each transfer is taken when write-enable rises while chip-enable is low. The first byte of a transfer selects what later reads return: the cell array, the status byte, or the two identifier bytes. It can also clear the sticky status flags or open a two-cycle byte-write or block-erase sequence.

A small sequencer runs each accepted operation. It holds the ready/busy output low for a parameterised number of clock cycles, then commits the result to a small on-chip register array that stands in for the flash cells. The programming-voltage-good input is sampled only on the second bus cycle of a write or erase sequence, not at any other time. A failed check is recorded in sticky status flags, and those flags stay set until software clears them.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, ready is high and reads return the cell array. Every cell reads FFh, and the status byte reads 80h.
- R2: After command 90h, a read at address 0 returns 89h, a read at address 1 returns A2h, and any other address returns 00h. This works whatever the level of the voltage-good input.
- R3: A bus transfer is taken only on a rising edge of write-enable while chip-enable is low. Write-enable toggling while chip-enable is high changes nothing.
- R4: After command 70h, reads return the status byte. Bit 7 is 1 when ready and 0 when busy. Bit 6 (erase suspended) and bits 2..0 always read 0.
- R5: Command 40h followed by a second transfer (address, data) stores the old byte AND the data at that address. After 40h, reads return the status byte.
- R6: Command 20h followed by D0h sets every byte of the block that holds the confirm address to FFh. A block is 2^BLOCK_W bytes, selected by address bits ADDR_W-1..BLOCK_W. Bytes in other blocks are unchanged.
- R7: If the transfer after 20h carries any byte other than D0h, status bits 5 and 4 are both set. Ready stays high and the array is unchanged.
- R8: The voltage-good input is sampled only on the second transfer of a write or erase sequence. If it is low there, status bit 3 is set together with bit 4 (write) or bit 5 (erase). No busy period starts and the array is unchanged.
- R9: Status bits 5..3 stay set until command 50h, and 50h clears all three.
- R10: An accepted operation holds ready low for exactly BUSY_CYC cycles. Bus transfers during that time are ignored.
- R11: Command FFh returns reads to the cell array. Unknown command bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low; transfer taken on its rising edge |
| addr | input | ADDR_W | Byte address for reads and transfers |
| wdata | input | 8 | Command or data byte |
| vppOk | input | 1 | Programming voltage present |
| rdata | output | 8 | Read data for the current read mode |
| readyOut | output | 1 | High when no operation is running |

## Verification
The bench drives the main sequences one after another. First comes a byte write onto an erased byte, then a second write to the same byte, which shows that AND-merging differs from overwriting. Next, an erase of a block that holds programmed bytes next to a programmed byte in another block shows that the block boundary is decoded. A bad confirm byte and a low voltage level, each on both sequences, tell the three error flag patterns apart. Transfers issued during busy and write-enable toggling with chip-enable high show that input is ignored when it should be.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLEAR_STAT  = 8'h50;
  localparam logic [7:0] CMD_IDENT       = 8'h90;
  localparam logic [7:0] CMD_WRITE_SETUP = 8'h40;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] ID_MAKER        = 8'h89;
  localparam logic [7:0] ID_PART         = 8'hA2;

  typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_IDENT} readMode_t;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_WRITE, SEQ_ERASE} seq_t;

  typedef struct packed {
    logic capture;
    logic progByte;
    logic eraseBlk;
  } dpStrobe_t;
endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int BUSY_CYC = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       weN,
  input  logic [7:0] wdata,
  input  logic       vppOk,
  output dpStrobe_t  strobe,
  output readMode_t  readMode,
  output logic [7:0] statusByte,
  output logic       readyOut
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic             weQ;
  logic             busEdge;
  logic [CNT_W-1:0] busyCnt;
  logic             busy;
  logic             opErase;
  seq_t             seq;
  logic             errErase, errWrite, vppLow;

  assign busEdge = !ceN && !weQ && weN;
  assign busy    = (busyCnt != '0);

  always_comb begin
    strobe          = '0;
    strobe.capture  = busEdge && !busy && (seq != SEQ_IDLE);
    strobe.progByte = busy && (busyCnt == CNT_LAST) && !opErase;
    strobe.eraseBlk = busy && (busyCnt == CNT_LAST) && opErase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weQ      <= 1'b1;
      busyCnt  <= '0;
      opErase  <= 1'b0;
      seq      <= SEQ_IDLE;
      readMode <= RD_ARRAY;
      errErase <= 1'b0;
      errWrite <= 1'b0;
      vppLow   <= 1'b0;
    end else begin
      weQ <= weN;
      if (busy) begin
        busyCnt <= busyCnt - CNT_LAST;
      end else if (busEdge) begin
        case (seq)
          SEQ_WRITE: begin
            seq <= SEQ_IDLE;
            if (vppOk) begin
              busyCnt <= CNT_LOAD;
              opErase <= 1'b0;
            end else begin
              vppLow   <= 1'b1;
              errWrite <= 1'b1;
            end
          end
          SEQ_ERASE: begin
            seq <= SEQ_IDLE;
            if (wdata != CMD_ERASE_GO) begin
              errErase <= 1'b1;
              errWrite <= 1'b1;
            end else if (vppOk) begin
              busyCnt <= CNT_LOAD;
              opErase <= 1'b1;
            end else begin
              vppLow   <= 1'b1;
              errErase <= 1'b1;
            end
          end
          default: begin
            case (wdata)
              CMD_READ_ARRAY:  readMode <= RD_ARRAY;
              CMD_READ_STATUS: readMode <= RD_STATUS;
              CMD_IDENT:       readMode <= RD_IDENT;
              CMD_CLEAR_STAT: begin
                errErase <= 1'b0;
                errWrite <= 1'b0;
                vppLow   <= 1'b0;
              end
              CMD_WRITE_SETUP: begin
                seq      <= SEQ_WRITE;
                readMode <= RD_STATUS;
              end
              CMD_ERASE_SETUP: begin
                seq      <= SEQ_ERASE;
                readMode <= RD_STATUS;
              end
              default: ;
            endcase
          end
        endcase
      end
    end
  end

  assign statusByte = {~busy, 1'b0, errErase, errWrite, vppLow, 3'b000};
  assign readyOut   = ~busy;
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BLOCK_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  readMode_t         readMode,
  input  logic [7:0]        statusByte,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        cells [DEPTH];
  logic [ADDR_W-1:0] opAddr;
  logic [7:0]        opData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opAddr <= '0;
      opData <= '0;
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else begin
      if (strobe.capture) begin
        opAddr <= addr;
        opData <= wdata;
      end
      if (strobe.progByte) cells[opAddr] <= cells[opAddr] & opData;
      if (strobe.eraseBlk) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (ADDR_W'(i) >> BLOCK_W == opAddr >> BLOCK_W) cells[i] <= 8'hFF;
        end
      end
    end
  end

  always_comb begin
    case (readMode)
      RD_STATUS: rdata = statusByte;
      RD_IDENT:  rdata = (addr == ADDR_W'(0)) ? ID_MAKER :
                         (addr == ADDR_W'(1)) ? ID_PART  : 8'h00;
      default:   rdata = cells[addr];
    endcase
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int BLOCK_W  = 4,
  parameter int BUSY_CYC = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              vppOk,
  output logic [7:0]        rdata,
  output logic              readyOut
);
  dpStrobe_t  strobe;
  readMode_t  readMode;
  logic [7:0] statusByte;

  flash_cmd_fsm #(.BUSY_CYC(BUSY_CYC)) u_fsm (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .wdata(wdata),
    .vppOk(vppOk), .strobe(strobe), .readMode(readMode),
    .statusByte(statusByte), .readyOut(readyOut)
  );

  flash_cell_array #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) u_cells (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr), .wdata(wdata),
    .readMode(readMode), .statusByte(statusByte), .rdata(rdata)
  );
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int BUSY_CYC = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              vppOk,
  input logic [7:0]        rdata,
  input logic              readyOut,
  input readMode_t         readMode,
  input logic [7:0]        statusByte
);
  int lowRun;
  always_ff @(posedge clk) begin
    if (!rstN) lowRun <= 0;
    else if (!readyOut) lowRun <= lowRun + 1;
    else lowRun <= 0;
  end

  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[6] == 1'b0 && statusByte[2:0] == 3'b000);

  a_r2_ident_maker: assert property (@(posedge clk) disable iff (!rstN)
    (readMode == RD_IDENT && addr == ADDR_W'(0)) |-> rdata == 8'h89);

  a_r8_start_needs_vpp: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyOut) |-> $past(vppOk));

  a_r9_sticky_until_clear: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(statusByte[5:3]) & ~statusByte[5:3])) |-> $past(wdata) == 8'h50);

  a_r10_busy_bounded: assert property (@(posedge clk) disable iff (!rstN)
    lowRun <= BUSY_CYC);

  a_r10_busy_exact: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyOut) |-> lowRun == BUSY_CYC);

  a_r10_mode_held_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!readyOut && $past(!readyOut)) |-> $stable(readMode));
endmodule

bind flash_cmd_ctrl flash_cmd_chk #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wdata(wdata), .vppOk(vppOk),
  .rdata(rdata), .readyOut(readyOut), .readMode(readMode),
  .statusByte(statusByte)
);

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;
  localparam int BLOCK_W    = 4;
  localparam int BUSY_CYC   = 8;
  localparam int DEPTH      = 1 << ADDR_W;

  logic clk = 0, rstN = 0, ceN = 1, weN = 1, vppOk = 1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic readyOut;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W), .BUSY_CYC(BUSY_CYC)) dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .addr(addr),
    .wdata(wdata), .vppOk(vppOk), .rdata(rdata), .readyOut(readyOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  string curReq = "R1";

  // Reference model state
  int mMem [DEPTH];
  int mMode;      // 0 array, 1 status, 2 ident
  int mSeq;       // 0 idle, 1 write pending, 2 erase pending
  int mBusy;
  int mOpKind;    // 0 program, 1 erase
  int mOpAddr, mOpData;
  bit mE5, mE4, mV3, mPrevWe;

  function automatic int modelRead(int a);
    if (mMode == 1) return ((mBusy == 0) << 7) | (mE5 << 5) | (mE4 << 4) | (mV3 << 3);
    if (mMode == 2) return (a == 0) ? 'h89 : (a == 1) ? 'hA2 : 0;
    return mMem[a];
  endfunction

  task automatic modelStep();
    bit edgeSeen;
    if (!rstN) begin
      foreach (mMem[i]) mMem[i] = 'hFF;
      mMode = 0; mSeq = 0; mBusy = 0; mOpKind = 0; mOpAddr = 0; mOpData = 0;
      mE5 = 0; mE4 = 0; mV3 = 0; mPrevWe = 1;
      return;
    end
    edgeSeen = !ceN && !mPrevWe && weN;
    mPrevWe = weN;
    if (mBusy > 0) begin
      if (mBusy == 1) begin
        if (mOpKind == 0) mMem[mOpAddr] = mMem[mOpAddr] & mOpData;
        else foreach (mMem[i]) if ((i / (1 << BLOCK_W)) == (mOpAddr / (1 << BLOCK_W))) mMem[i] = 'hFF;
      end
      mBusy--;
    end else if (edgeSeen) begin
      if (mSeq == 1) begin
        mSeq = 0;
        if (vppOk) begin mBusy = BUSY_CYC; mOpKind = 0; mOpAddr = addr; mOpData = wdata; end
        else begin mV3 = 1; mE4 = 1; end
      end else if (mSeq == 2) begin
        mSeq = 0;
        if (wdata != 'hD0) begin mE5 = 1; mE4 = 1; end
        else if (vppOk) begin mBusy = BUSY_CYC; mOpKind = 1; mOpAddr = addr; end
        else begin mV3 = 1; mE5 = 1; end
      end else begin
        case (wdata)
          'hFF: mMode = 0;
          'h70: mMode = 1;
          'h90: mMode = 2;
          'h50: begin mE5 = 0; mE4 = 0; mV3 = 0; end
          'h40: begin mSeq = 1; mMode = 1; end
          'h20: begin mSeq = 2; mMode = 1; end
          default: ;
        endcase
      end
    end
  endtask

  always @(posedge clk) begin
    modelStep();
    #(CLK_PERIOD/4);
    if (rstN && !finished) begin
      nChecks++;
      if (rdata !== 8'(modelRead(int'(addr)))) begin
        nFails++;
        $display("FAIL %s rdata addr=%0d actual=%02h expected=%02h", curReq, addr, rdata, 8'(modelRead(int'(addr))));
      end
      nChecks++;
      if (readyOut !== (mBusy == 0)) begin
        nFails++;
        $display("FAIL %s readyOut actual=%0b expected=%0b", curReq, readyOut, (mBusy == 0));
      end
    end
  end

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d, input bit selected = 1);
    @(negedge clk); ceN = !selected; addr = a; wdata = d; weN = 0;
    @(negedge clk); weN = 1;
    @(negedge clk); ceN = 1;
  endtask

  task automatic readAt(input logic [ADDR_W-1:0] a);
    @(negedge clk); addr = a;
    @(negedge clk);
  endtask

  task automatic waitIdle();
    repeat (BUSY_CYC + 3) @(negedge clk);
  endtask

  task automatic finish();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state, array reads erased
    curReq = "R1";
    readAt(5); readAt(40);
    busWrite(0, 8'h70); readAt(0);
    // R2: identifiers with voltage absent
    curReq = "R2";
    vppOk = 0;
    busWrite(0, 8'h90);
    readAt(0); readAt(1); readAt(2);
    vppOk = 1;
    // R3: strobes with chip-enable high ignored
    curReq = "R3";
    busWrite(0, 8'hFF, 0); readAt(1);
    // R11: back to array, unknown byte ignored
    curReq = "R11";
    busWrite(0, 8'hFF); readAt(5);
    busWrite(0, 8'h13); readAt(5);
    // R5: byte write onto erased byte, then AND-merge
    curReq = "R5";
    busWrite(5, 8'h40); busWrite(5, 8'h3C);
    // R10: transfers during busy ignored
    curReq = "R10";
    busWrite(0, 8'h90);
    waitIdle();
    // R4: status reads ready after op
    curReq = "R4";
    readAt(0);
    curReq = "R5";
    busWrite(0, 8'hFF); readAt(5);
    busWrite(5, 8'h40); busWrite(5, 8'hF0); waitIdle();
    busWrite(0, 8'hFF); readAt(5);
    busWrite(17, 8'h40); busWrite(17, 8'h0F); waitIdle();
    busWrite(30, 8'h40); busWrite(30, 8'h55); waitIdle();
    // R6: erase block 1, block 0 untouched
    curReq = "R6";
    busWrite(20, 8'h20); busWrite(20, 8'hD0); waitIdle();
    busWrite(0, 8'hFF); readAt(17); readAt(30); readAt(5); readAt(16); readAt(32);
    // R7: bad confirm byte
    curReq = "R7";
    busWrite(5, 8'h20); busWrite(5, 8'h33); readAt(0);
    busWrite(0, 8'hFF); readAt(5);
    // R9: flags stay, then clear
    curReq = "R9";
    busWrite(0, 8'h70); readAt(3);
    busWrite(0, 8'h50); readAt(3);
    // R8: low voltage on write, then on erase
    curReq = "R8";
    busWrite(40, 8'h40); vppOk = 0; busWrite(40, 8'h00); readAt(0);
    vppOk = 1; busWrite(0, 8'hFF); readAt(40);
    busWrite(0, 8'h50);
    busWrite(40, 8'h20); vppOk = 0; busWrite(40, 8'hD0); vppOk = 1; readAt(0);
    busWrite(0, 8'h50); busWrite(0, 8'h70); readAt(0);
    // R8: low voltage during setup only does not block
    vppOk = 0; busWrite(40, 8'h40); vppOk = 1; busWrite(40, 8'h0F); waitIdle();
    busWrite(0, 8'hFF); readAt(40);
    repeat (4) @(negedge clk);
    finish();
  end
endmodule